// File: doc/BRIEF.md
# Hex Seven-Segment Decoder Chain with Leading-Zero Suppression

This block turns a multi-digit hexadecimal number into active-low drives for a row of seven-segment displays. Each digit position holds a plain hex-to-glyph decoder and a small zero-suppression stage. A digit whose blank-enable input is asserted and whose value is zero goes fully dark. It then passes the blank-enable on to the next less significant position.

A zero is suppressed only while every more significant digit is also a suppressed zero. The first nonzero digit breaks the chain, so every digit after it is shown, zeros included. The least significant position never receives a blank-enable. A value of zero therefore still shows a single "0". The caller controls suppression as a whole through one active-low input at the most significant position. The block is purely combinational: it has no clock, no reset and no storage.

Top module: `hex_rb_display`

## Requirements
- R1: Each digit's 7-bit segment field is active-low (0 lights a segment) in bit order a,b,c,d,e,f,g from bit 6 down to bit 0. Digit k drives `seg_no[7*k+6:7*k]` from `digits_i[4*k+3:4*k]`, with k=0 the least significant. The glyphs are 0-9 plus A, b, C, d, E, F in their usual shapes (for example 0 -> 7'h01, 8 -> 7'h00, b -> 7'h60).
- R2: When a digit is 0 and its blank-enable input is low, all seven of its segment bits are 1 (dark).
- R3: A digit's ripple output `blank_out_no[k]` is low only when that digit is 0 and its blank-enable input is low; otherwise it is high.
- R4: A nonzero digit always shows its glyph, and its ripple output is high, whatever its blank-enable input.
- R5: A zero digit whose blank-enable input is high shows the "0" glyph (7'h01).
- R6: The most significant digit takes its blank-enable from `blank_in_ni`. Each lower digit except digit 0 takes it from `blank_out_no` of the digit above.
- R7: Digit 0's blank-enable is tied high. An all-zero value with suppression enabled shows one "0", and `blank_out_no[0]` is always high.
- R8: The outputs depend only on the present inputs, with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digits_i | input | 16 | Hex digits, digit 0 in bits 3:0 |
| blank_in_ni | input | 1 | Active-low leading-zero suppression enable for the most significant digit |
| seg_no | output | 28 | Active-low segments, 7 bits per digit, digit 0 in bits 6:0 |
| blank_out_no | output | 4 | Active-low ripple output of each digit |

## Verification
A wrong glyph or a wrong blanking decision shows at once in the segment field of the affected digit. A break in the ripple path shows one digit further down: a leading zero stays lit, or a zero after a nonzero digit goes dark. Every output settles within the same input change. Each stimulus is therefore compared half a clock period after it is applied, against a position-by-position model of the chain.

// File: rtl/hex_rb_pkg.sv
package hex_rb_pkg;
  localparam int NIB_W = 4;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_DARK = '1;
endpackage

// File: rtl/hex_glyph_dec.sv
module hex_glyph_dec
  import hex_rb_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output seg_t             seg_no
);
  seg_t lit;  // active-high, a..g = bit 6..0

  always_comb begin
    unique case (nib_i)
      4'h0: lit = 7'b1111110;
      4'h1: lit = 7'b0110000;
      4'h2: lit = 7'b1101101;
      4'h3: lit = 7'b1111001;
      4'h4: lit = 7'b0110011;
      4'h5: lit = 7'b1011011;
      4'h6: lit = 7'b1011111;
      4'h7: lit = 7'b1110000;
      4'h8: lit = 7'b1111111;
      4'h9: lit = 7'b1111011;
      4'ha: lit = 7'b1110111;
      4'hb: lit = 7'b0011111;
      4'hc: lit = 7'b1001110;
      4'hd: lit = 7'b0111101;
      4'he: lit = 7'b1001111;
      default: lit = 7'b1000111;
    endcase
  end

  assign seg_no = ~lit;

  // R1
  always_comb begin
    glyph_lit_chk: assert ($countones(~seg_no) >= 2)
      else $error("glyph lights fewer than two segments");
  end
endmodule

// File: rtl/rb_zero_ctl.sv
module rb_zero_ctl
  import hex_rb_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  input  logic             blank_in_ni,
  output logic             blank_o,
  output logic             blank_out_no
);
  logic zero;

  assign zero         = ~|nib_i;
  assign blank_o      = zero & ~blank_in_ni;
  assign blank_out_no = ~blank_o;
endmodule

// File: rtl/hex_rb_cell.sv
module hex_rb_cell
  import hex_rb_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  input  logic             blank_in_ni,
  output seg_t             seg_no,
  output logic             blank_out_no
);
  seg_t glyph;
  logic blank;

  hex_glyph_dec u_dec (
    .nib_i  (nib_i),
    .seg_no (glyph)
  );

  rb_zero_ctl u_ctl (
    .nib_i        (nib_i),
    .blank_in_ni  (blank_in_ni),
    .blank_o      (blank),
    .blank_out_no (blank_out_no)
  );

  assign seg_no = blank ? SEG_DARK : glyph;

  always_comb begin
    // R2
    if (nib_i == '0 && !blank_in_ni)
      blank_zero_chk: assert (seg_no == SEG_DARK)
        else $error("suppressed zero not dark");
    // R3
    ripple_dark_chk: assert (blank_out_no || seg_no == SEG_DARK)
      else $error("ripple asserted on a lit digit");
    // R4
    if (nib_i != '0)
      nonzero_shown_chk: assert (seg_no != SEG_DARK && blank_out_no)
        else $error("nonzero digit blanked");
    // R5
    if (blank_in_ni)
      enable_off_chk: assert (seg_no != SEG_DARK && blank_out_no)
        else $error("digit blanked without enable");
  end
endmodule

// File: rtl/hex_rb_display.sv
module hex_rb_display
  import hex_rb_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int DIG_BUS = DIGITS * NIB_W,
  localparam int SEG_BUS = DIGITS * SEG_W
) (
  input  logic [DIG_BUS-1:0] digits_i,
  input  logic               blank_in_ni,
  output logic [SEG_BUS-1:0] seg_no,
  output logic [DIGITS-1:0]  blank_out_no
);
  logic [DIGITS-1:0] en_n;

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    if (k == 0) begin : g_lsd
      assign en_n[k] = 1'b1;  // keep a lone "0" visible
    end else if (k == DIGITS - 1) begin : g_msd
      assign en_n[k] = blank_in_ni;
    end else begin : g_mid
      assign en_n[k] = blank_out_no[k+1];
    end

    hex_rb_cell u_cell (
      .nib_i        (digits_i[k*NIB_W +: NIB_W]),
      .blank_in_ni  (en_n[k]),
      .seg_no       (seg_no[k*SEG_W +: SEG_W]),
      .blank_out_no (blank_out_no[k])
    );
  end

  // R7
  always_comb begin
    lsd_visible_chk: assert (blank_out_no[0] && seg_no[SEG_W-1:0] != SEG_DARK)
      else $error("least significant digit blanked");
  end
endmodule

// File: tb/tb_hex_rb_display.sv
module tb_hex_rb_display;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [4*N-1:0] digits_i = '0;
  logic           blank_in_ni = 1'b1;
  logic [7*N-1:0] seg_no;
  logic [N-1:0]   blank_out_no;

  hex_rb_display #(.DIGITS(N)) dut (
    .digits_i     (digits_i),
    .blank_in_ni  (blank_in_ni),
    .seg_no       (seg_no),
    .blank_out_no (blank_out_no)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit drv_done = 1'b0;

  logic [7*N-1:0] exp_seg_q[$];
  logic [N-1:0]   exp_rip_q[$];
  string          tag_q[$];

  function automatic logic [6:0] glyph(input logic [3:0] d);
    logic [6:0] l;
    case (d)
      4'h0: l = 7'h7e; 4'h1: l = 7'h30; 4'h2: l = 7'h6d; 4'h3: l = 7'h79;
      4'h4: l = 7'h33; 4'h5: l = 7'h5b; 4'h6: l = 7'h5f; 4'h7: l = 7'h70;
      4'h8: l = 7'h7f; 4'h9: l = 7'h7b; 4'ha: l = 7'h77; 4'hb: l = 7'h1f;
      4'hc: l = 7'h4e; 4'hd: l = 7'h3d; 4'he: l = 7'h4f; default: l = 7'h47;
    endcase
    return ~l;
  endfunction

  task automatic drive(input logic [4*N-1:0] d, input logic b, input string tag);
    logic [7*N-1:0] es;
    logic [N-1:0]   er;
    logic           en;
    en = b;
    for (int k = N - 1; k >= 0; k--) begin
      logic in_n, blk;
      logic [3:0] nib;
      nib = d[4*k +: 4];
      in_n = (k == 0) ? 1'b1 : en;
      blk = (nib == 4'h0) && !in_n;
      es[7*k +: 7] = blk ? 7'h7f : glyph(nib);
      er[k] = !blk;
      en = !blk;
    end
    @(posedge clk);
    digits_i = d;
    blank_in_ni = b;
    exp_seg_q.push_back(es);
    exp_rip_q.push_back(er);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_ni && exp_seg_q.size() > 0) begin
      logic [7*N-1:0] es;
      logic [N-1:0]   er;
      string t;
      es = exp_seg_q.pop_front();
      er = exp_rip_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (seg_no !== es || blank_out_no !== er) begin
        n_bad++;
        $display("FAIL %s in=%h en=%b seg=%h exp=%h rip=%b exp=%b",
                 t, digits_i, blank_in_ni, seg_no, es, blank_out_no, er);
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // R1 R2 R3 R4 R5: all 16 values at the MSD, enable low and high
    for (int v = 0; v < 16; v++) begin
      for (int b = 0; b < 2; b++) begin
        string t;
        if (v == 0 && b == 0) t = "R2 R3 blank zero";
        else if (v == 0) t = "R5 zero shown";
        else t = "R1 R4 glyph";
        drive({v[3:0], 12'h123}, b[0], t);
      end
    end
    // R6 R7 chain patterns
    drive(16'h0000, 1'b0, "R7 lone zero");
    drive(16'h0000, 1'b1, "R5 R6 all zeros shown");
    drive(16'h0005, 1'b0, "R6 three leading");
    drive(16'h0050, 1'b0, "R6 two leading");
    drive(16'h0500, 1'b0, "R6 one leading");
    drive(16'h1000, 1'b0, "R6 trailing zeros kept");
    drive(16'h0a0b, 1'b0, "R6 inner zero kept");
    drive(16'h00f0, 1'b0, "R6 R7 lsd zero kept");
    drive(16'h0050, 1'b1, "R6 suppression off");
    // R8: input change alone updates outputs
    drive(16'h0007, 1'b0, "R8 follow");
    drive(16'h7000, 1'b0, "R8 follow");
    @(posedge clk);
    @(posedge clk);
    drv_done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!drv_done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule